// File: doc/BRIEF.md
# Multi-Link Bank-Switch Trigger

This block is a shared control register that lets software switch register banks on up to four serial audio link controllers at the same instant. One 32-bit register, written and read over a simple single-cycle port, holds four things:

- a programmable sync period;
- a handshake bit that commits a new period;
- one arm bit per link;
- a go bit.

A free-running down-counter, started by the first period commit, produces a one-cycle sync pulse on every terminal count.

Software arms each link that takes part in a switch. It then writes go. The go write captures the armed set and clears the arm bits. The trigger then waits for the next sync boundary. At that boundary every captured link receives a one-cycle bank-switch strobe, in the same cycle as the sync pulse, and the go bit drops. Software polls the go bit to learn that the switch has been issued. In the same way, it polls the commit bit to learn that a new period is in force.

Top module: `trig_sync_ctrl`

## Requirements
- R1: After reset the register reads 0x0000_176F, and sync_o and bank_sw_o stay low for as long as no period commit has been written.
- R2: Register layout:
  - the period occupies bits 14:0;
  - the commit bit is bit 15;
  - the arm bit for link n is bit 16+n;
  - go is bit 24.
  All other bits read 0, and writing them has no effect.
- R3: A write with bit 15 set, while the counter is idle, starts it with the written period P. sync_o is then high for one cycle, P+1 cycles after the clock edge that accepted the write, and again every P+1 cycles.
- R4: Changing the period field with bit 15 clear does not change the pulse spacing. A commit written while the counter runs keeps the current spacing up to the next sync pulse. The committed period sets the spacing from that pulse on.
- R5: The commit bit reads 1 from the accepting edge until the next sync pulse, and reads 0 from that pulse on.
- R6: Arm bits read back as written and produce no strobe without a go.
- R7: A write with bit 24 set, while no go is pending, does four things:
  - it captures that write's arm bits;
  - it makes the arm bits read 0;
  - it makes go read 1 until the next sync pulse;
  - at that pulse it drives bank_sw_o with the captured set for one cycle, and go reads 0 from the same cycle.
- R8: A go written with no arm bit set produces no strobe, and still clears at the next sync pulse.
- R9: While a go is pending, a further write updates the arm bits, which are kept for a later go. Its go bit is ignored, and the pending go fires only the set it captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Live register contents |
| sync_o | output | 1 | One-cycle sync pulse at each period boundary |
| bank_sw_o | output | NUM_LINKS | One-cycle bank-switch strobe per link |

## Verification
A wrong count or a stale reload value shifts the cycle of sync_o. This shows at the first boundary after the fault and drifts at every boundary after it. A lost or doubled capture of the armed set shows as a wrong bank_sw_o mask at the single pulse that fires the go. A go or commit bit that fails to clear is visible on rd_data_o in the cycle after that pulse. Arm bits that are wrongly consumed show in the readback taken right after the write.

// File: rtl/trig_sync_pkg.sv
`timescale 1ns/1ps
package trig_sync_pkg;
  localparam int REG_W    = 32;
  localparam int PER_LSB  = 0;
  localparam int PER_W    = 15;
  localparam int LOAD_BIT = 15;
  localparam int ARM_LSB  = 16;
  localparam int ARM_MAX  = 4;
  localparam int GO_BIT   = 24;
  localparam logic [PER_W-1:0] PER_RST = 15'h176F;
endpackage

// File: rtl/trig_sync_timer.sv
`timescale 1ns/1ps
module trig_sync_timer
  import trig_sync_pkg::*;
#(
  parameter logic [PER_W-1:0] RST_PERIOD = PER_RST
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [PER_W-1:0] start_val_i,
  input  logic             load_i,
  input  logic [PER_W-1:0] period_i,
  output logic             tick_o,
  output logic             active_o,
  output logic             sync_o
);
  logic [PER_W-1:0] cnt_q, act_q;
  logic             active_q, sync_q;

  assign tick_o   = active_q && (cnt_q == '0);
  assign active_o = active_q;
  assign sync_o   = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      act_q    <= RST_PERIOD;
      active_q <= 1'b0;
      sync_q   <= 1'b0;
    end else begin
      sync_q <= tick_o;
      if (start_i) begin
        active_q <= 1'b1;
        cnt_q    <= start_val_i;
        act_q    <= start_val_i;
      end else if (tick_o) begin
        // committed period replaces the running one only at a boundary
        if (load_i) begin
          cnt_q <= period_i;
          act_q <= period_i;
        end else begin
          cnt_q <= act_q;
        end
      end else if (active_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assert_active_stays_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |=> active_q);
  assert_pulse_after_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> sync_q);
endmodule

// File: rtl/trig_sync_arm.sv
`timescale 1ns/1ps
module trig_sync_arm #(
  parameter int NUM_LINKS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [NUM_LINKS-1:0] wr_arm_i,
  input  logic                 wr_go_i,
  input  logic                 tick_i,
  output logic [NUM_LINKS-1:0] arm_o,
  output logic                 go_o,
  output logic [NUM_LINKS-1:0] bank_sw_o
);
  logic [NUM_LINKS-1:0] arm_q, fire_q, sw_q;
  logic                 go_q, go_accept;

  // a go write is taken only when no go is outstanding
  assign go_accept = wr_en_i && wr_go_i && !go_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q  <= '0;
      fire_q <= '0;
      sw_q   <= '0;
      go_q   <= 1'b0;
    end else begin
      if (wr_en_i) arm_q <= go_accept ? '0 : wr_arm_i;
      if (go_accept) fire_q <= wr_arm_i;
      if (go_accept)               go_q <= 1'b1;
      else if (tick_i && go_q)     go_q <= 1'b0;
      sw_q <= (tick_i && go_q) ? fire_q : '0;
    end
  end

  assign arm_o     = arm_q;
  assign go_o      = go_q;
  assign bank_sw_o = sw_q;

  assert_go_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && go_q) |=> (!go_q && (sw_q == $past(fire_q))));
  assert_strobe_needs_go_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_q != '0) |-> $past(go_q));
  assert_pending_kept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_q && !tick_i) |=> (go_q && $stable(fire_q)));
endmodule

// File: rtl/trig_sync_ctrl.sv
`timescale 1ns/1ps
module trig_sync_ctrl
  import trig_sync_pkg::*;
#(
  parameter int                NUM_LINKS  = 4,
  parameter logic [PER_W-1:0]  RST_PERIOD = PER_RST
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [REG_W-1:0]     wr_data_i,
  output logic [REG_W-1:0]     rd_data_o,
  output logic                 sync_o,
  output logic [NUM_LINKS-1:0] bank_sw_o
);
  logic [PER_W-1:0]     prog_q;
  logic                 load_q, wr_load, start, tick, active;
  logic [NUM_LINKS-1:0] arm;
  logic                 go;

  assign wr_load = wr_en_i && wr_data_i[LOAD_BIT];
  assign start   = wr_load && !active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_q <= RST_PERIOD;
      load_q <= 1'b0;
    end else begin
      if (wr_en_i) prog_q <= wr_data_i[PER_LSB +: PER_W];
      if (wr_load)               load_q <= 1'b1;
      else if (tick && load_q)   load_q <= 1'b0;
    end
  end

  trig_sync_timer #(.RST_PERIOD(RST_PERIOD)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .start_val_i (wr_data_i[PER_LSB +: PER_W]),
    .load_i      (load_q),
    .period_i    (prog_q),
    .tick_o      (tick),
    .active_o    (active),
    .sync_o      (sync_o)
  );

  trig_sync_arm #(.NUM_LINKS(NUM_LINKS)) u_arm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_arm_i  (wr_data_i[ARM_LSB +: NUM_LINKS]),
    .wr_go_i   (wr_data_i[GO_BIT]),
    .tick_i    (tick),
    .arm_o     (arm),
    .go_o      (go),
    .bank_sw_o (bank_sw_o)
  );

  always_comb begin
    rd_data_o = '0;
    rd_data_o[PER_LSB +: PER_W]     = prog_q;
    rd_data_o[LOAD_BIT]             = load_q;
    rd_data_o[ARM_LSB +: NUM_LINKS] = arm;
    rd_data_o[GO_BIT]               = go;
  end

  assert_links_fit_R2: assert final (NUM_LINKS >= 1 && NUM_LINKS <= ARM_MAX);
  assert_load_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && load_q && !wr_load) |=> !load_q);
  assert_strobe_on_sync_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_sw_o != '0) |-> sync_o);
  assert_quiet_when_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> active);
endmodule

// File: tb/trig_sync_ctrl_tb.sv
`timescale 1ns/1ps
module trig_sync_ctrl_tb;
  localparam int NL = 4;

  logic          clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   rd_data;
  logic          sync;
  logic [NL-1:0] bank_sw;

  trig_sync_ctrl #(.NUM_LINKS(NL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .sync_o(sync), .bank_sw_o(bank_sw));

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0, n_pulse = 0;
  bit done = 0, mon_on = 1;
  string cur_tag = "R3";

  // expectation model from the requirements
  bit        started = 0, load_pend = 0, go_pend = 0;
  int        next_sync = 0, act_per = 0;
  logic [14:0] prog_per = 15'h176F;
  logic [3:0]  arm_m = '0, go_mask = '0;

  typedef struct { int c; logic [3:0] mask; } ev_t;
  ev_t exp_q[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic push_boundary();
    ev_t e;
    e.c = cyc;
    e.mask = go_pend ? go_mask : 4'b0;
    exp_q.push_back(e);
    go_pend = 0;
    if (load_pend) begin
      act_per = int'(prog_per);
      load_pend = 0;
    end
    next_sync = cyc + act_per + 1;
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    #3;
    if (rst_n && mon_on) begin
      if (started && cyc == next_sync) push_boundary();
      if (sync || bank_sw != '0) begin
        n_pulse++;
        if (exp_q.size() == 0) begin
          chk(0, {cur_tag, " unexpected pulse"}, {27'b0, sync, bank_sw}, 32'h0);
        end else begin
          ev_t e;
          e = exp_q.pop_front();
          chk(e.c == cyc && sync, {cur_tag, " sync timing"}, cyc, e.c);
          chk(bank_sw == e.mask, "R7 strobe mask", {28'b0, bank_sw}, {28'b0, e.mask});
        end
      end else if (exp_q.size() != 0 && exp_q[0].c <= cyc) begin
        chk(0, {cur_tag, " missing sync"}, cyc, exp_q[0].c);
        void'(exp_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    while (started && cyc + 1 == next_sync) @(negedge clk);
    wr_data = d;
    wr_en = 1'b1;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    prog_per = d[14:0];
    if (d[15]) begin
      load_pend = 1;
      if (!started) begin
        started = 1;
        act_per = int'(d[14:0]);
        next_sync = cyc + act_per + 1;
      end
    end
    if (d[24] && !go_pend) begin
      go_pend = 1;
      go_mask = d[19:16];
      arm_m = '0;
    end else begin
      arm_m = d[19:16];
    end
  endtask

  task automatic rd_chk(input string req);
    logic [31:0] exp;
    @(negedge clk);
    exp = {7'b0, go_pend, 4'b0, arm_m, load_pend, prog_per};
    chk(rd_data == exp, req, rd_data, exp);
  endtask

  task automatic wait_bounds(input int k);
    for (int i = 0; i < k; i++) begin
      int t;
      t = next_sync;
      while (cyc <= t) @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected run end (cycle)", cyc);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, idle counter
    cur_tag = "R1";
    rd_chk("R1 reset value");
    chk(rd_data == 32'h0000_176F, "R1 reset literal", rd_data, 32'h0000_176F);
    repeat (30) @(negedge clk);
    chk(n_pulse == 0, "R1 idle no pulses", n_pulse, 0);
    // R2 reserved bits ignored, no commit keeps counter idle
    wr(32'h7EE0_0005);
    rd_chk("R2 reserved bits read 0");
    chk(rd_data == 32'h0000_0005, "R2 readback literal", rd_data, 32'h0000_0005);
    repeat (20) @(negedge clk);
    chk(n_pulse == 0, "R3 idle without commit", n_pulse, 0);
    // R3 start, R5 commit bit handshake
    cur_tag = "R3";
    wr(32'h0000_8005);
    rd_chk("R5 commit reads 1");
    wait_bounds(3);
    rd_chk("R5 commit cleared");
    chk(rd_data[15] == 1'b0, "R5 commit bit low", rd_data, 32'h0);
    // R6 arm without go
    cur_tag = "R6";
    wr(32'h0005_0005);
    rd_chk("R6 arm readback");
    wait_bounds(2);
    rd_chk("R6 arm kept no strobe");
    // R7 go fires captured set
    cur_tag = "R7";
    wait_bounds(1);
    wr(32'h010B_0005);
    rd_chk("R7 arm cleared go pending");
    wait_bounds(1);
    rd_chk("R7 go cleared");
    // R8 go with nothing armed
    cur_tag = "R8";
    wait_bounds(1);
    wr(32'h0100_0005);
    rd_chk("R8 go pending");
    wait_bounds(1);
    rd_chk("R8 go cleared");
    // R9 arm while pending
    cur_tag = "R9";
    wait_bounds(1);
    wr(32'h0101_0005);
    wr(32'h0106_0005);
    rd_chk("R9 new arms kept, go pending");
    wait_bounds(1);
    rd_chk("R9 arms survive fire");
    wr(32'h0106_0005);
    wait_bounds(1);
    rd_chk("R9 second go fired");
    // R4 period change without and with commit
    cur_tag = "R4";
    wr(32'h0000_0009);
    wait_bounds(2);
    rd_chk("R4 uncommitted period readback");
    wr(32'h0000_8009);
    rd_chk("R4 commit pending");
    wait_bounds(3);
    rd_chk("R4 committed period");
    mon_on = 0;
    chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule